// File: doc/BRIEF.md
# Battery Charger Mode Sequencer

This block steps a battery charger through its operating phases using digital comparator flags from the analog front end. The flags report that the battery is above the precharge threshold, that it has reached the regulation voltage, that the current is below the termination level, and that the current is below one fifth of the fast-charge setting. A power-good flag, a supplement-mode flag and a 3-bit battery temperature zone complete the inputs. The sequence runs precharge, constant-current, constant-voltage, top-off and done. In a cool or warm zone the block uses a temperature-adjusted version of each of these phases.

Three minute-based timers guard the sequence: a fixed precharge limit, a selectable fast-charge limit and a selectable top-off duration. All three advance on an external one-minute tick. The block reports its phase as a 4-bit code. It also drives a charging flag, a timer-suspended flag and a one-cycle pulse on every change of the code. The timer scales are parameters, so a small configuration can be tested in few cycles.

Top module: `chg_mode_ctrl`

## Requirements
- R1: After reset the code is 0 (off) and the charging, suspended and change-pulse outputs are 0. The code is always in the range 0 to 12: 0 off, 1 precharge, 2/3 constant-current, 4/5 constant-voltage, 6/7 top-off, 8/9 done, 10 precharge timer fault, 11 fast-charge timer fault, 12 temperature fault. In each pair the odd code is the temperature-adjusted variant.
- R2: When the enable input or the power-good input is 0, the code becomes 0 at the next clock edge, whatever state the block is in. Every timer restarts from zero afterwards.
- R3: From off, with both enable and power-good at 1, the block moves to 12 if the zone is cold (1) or hot (4). For any other zone (0 disabled, 2 cool, 3 warm, 5 normal) it moves to 1.
- R4: Precharge moves to constant-current when the battery is above the precharge threshold. Constant-current moves to constant-voltage at the regulation voltage. Constant-voltage moves to top-off when the current is below termination. Top-off moves to done after topSel*TOPOFF_STEP_MIN minute ticks in top-off; a topSel of 0 means done one cycle after entry.
- R5: In the constant-current, constant-voltage and top-off phases the code is odd when the zone is cool (2) or warm (3) and even otherwise. The variant is re-evaluated on every cycle.
- R6: Done is reported as 9 if the block has occupied code 3, 5 or 7 since it last left off. Otherwise done is reported as 8.
- R7: After PQ_LIMIT_MIN unsuspended ticks in precharge the block enters 10. This takes priority over a same-cycle precharge threshold crossing. The block stays in 10 until the condition of R2 occurs.
- R8: The fast-charge timer counts unsuspended ticks across constant-current and constant-voltage. Its limit is (2*fastSel+1)*HOUR_MIN ticks for fastSel 1 to 3, and fastSel 0 disables it. When the limit is reached the block enters 11. This takes priority over a same-cycle phase advance, and the block stays in 11 until the condition of R2 occurs.
- R9: A cold or hot zone in codes 1 to 9 moves the block to 12 at the next edge. When the zone leaves cold and hot, the block resumes the phase it left, using the variant for the current zone, and the timer counts are kept.
- R10: The suspended output is 1 in constant-current while the current is below one fifth of the fast-charge setting, in codes 1 to 7 while supplement mode is active, and in code 12. While it is 1, no timer advances.
- R11: The charging output is 1 exactly when the code is 1 to 7 and supplement mode is inactive.
- R12: The change pulse is 1 for exactly one cycle, in the same cycle that the code first shows a new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| chgEnable | input | 1 | Charging permitted |
| powerGood | input | 1 | Input supply valid |
| battAbovePq | input | 1 | Battery above precharge threshold |
| battAtReg | input | 1 | Battery at regulation voltage |
| currBelowTerm | input | 1 | Charge current below termination |
| currBelowCcLow | input | 1 | Charge current below one fifth of the fast setting |
| supplementMode | input | 1 | Battery supplementing the system load |
| tempZone | input | 3 | Battery temperature zone (0 off, 1 cold, 2 cool, 3 warm, 4 hot, 5 normal) |
| fastSel | input | 2 | Fast-charge timer select |
| topSel | input | 3 | Top-off duration select |
| minuteTick | input | 1 | One-cycle pulse per minute |
| stateCode | output | 4 | Current phase code |
| charging | output | 1 | Charge flowing into the battery |
| timerSuspended | output | 1 | Active timer frozen |
| stateChangePulse | output | 1 | One-cycle pulse on code change |

## Verification
The most delicate collision is a timer reaching its limit in the same cycle that a comparator asks for the next phase. Examples are the precharge limit against the threshold crossing, and the fast-charge limit against a termination condition in constant-voltage. The bench provokes each collision by raising the phase-advance flag in the cycle right after the final tick, when the count has just reached its limit. It then expects the fault code rather than the next phase. A second pairing, a temperature fault arriving while the fast timer is part-way through, is judged by counting how many further ticks lead to the fault after the block resumes.

// File: rtl/chg_pkg.sv
package chg_pkg;

  typedef enum logic [3:0] {
    ST_OFF      = 4'd0,
    ST_PREQ     = 4'd1,
    ST_CC       = 4'd2,
    ST_CC_T     = 4'd3,
    ST_CV       = 4'd4,
    ST_CV_T     = 4'd5,
    ST_TOP      = 4'd6,
    ST_TOP_T    = 4'd7,
    ST_DONE     = 4'd8,
    ST_DONE_T   = 4'd9,
    ST_PQ_FLT   = 4'd10,
    ST_FC_FLT   = 4'd11,
    ST_TEMP_FLT = 4'd12
  } chgState_e;

  // strobes from the control to the timer datapath
  typedef struct packed {
    logic holdClear;
    logic runPq;
    logic runFast;
    logic runTop;
  } tmrCtl_t;

  localparam logic [2:0] ZONE_COLD = 3'd1;
  localparam logic [2:0] ZONE_COOL = 3'd2;
  localparam logic [2:0] ZONE_WARM = 3'd3;
  localparam logic [2:0] ZONE_HOT  = 3'd4;

endpackage

// File: rtl/chg_min_counter.sv
module chg_min_counter #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             reached
);
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         count <= '0;
    else if (clear)                    count <= '0;
    else if (run && tick && !reached)  count <= count + 1'b1;
  end

  assign reached = (count >= limit);

  // R10: a counter that is not running keeps its value
  p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!clear && !run) |=> $stable(count));

  // R2: clearing returns the count to zero
  p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (count == '0));

endmodule

// File: rtl/chg_timer_dp.sv
module chg_timer_dp
  import chg_pkg::*;
#(
  parameter int PQ_LIMIT_MIN    = 30,
  parameter int HOUR_MIN        = 60,
  parameter int TOPOFF_STEP_MIN = 5
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    minuteTick,
  input  tmrCtl_t ctl,
  input  logic [1:0] fastSel,
  input  logic [2:0] topSel,
  output logic    pqDone,
  output logic    fastDone,
  output logic    topDone
);
  localparam int FAST_MAX = 7 * HOUR_MIN;
  localparam int TOP_MAX  = 7 * TOPOFF_STEP_MIN;
  localparam int MAX_A    = (FAST_MAX > TOP_MAX) ? FAST_MAX : TOP_MAX;
  localparam int MAX_LIM  = (MAX_A > PQ_LIMIT_MIN) ? MAX_A : PQ_LIMIT_MIN;
  localparam int CNT_W    = $clog2(MAX_LIM + 1);
  localparam int N_TMR    = 3;

  logic [N_TMR-1:0][CNT_W-1:0] limVec;
  logic [N_TMR-1:0]            runVec;
  logic [N_TMR-1:0]            hitVec;

  always_comb begin
    limVec[0] = CNT_W'(PQ_LIMIT_MIN);
    limVec[1] = CNT_W'((2 * int'(fastSel) + 1) * HOUR_MIN);
    limVec[2] = CNT_W'(int'(topSel) * TOPOFF_STEP_MIN);
    runVec    = {ctl.runTop, ctl.runFast, ctl.runPq};
  end

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    chg_min_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rstN    (rstN),
      .clear   (ctl.holdClear),
      .run     (runVec[g]),
      .tick    (minuteTick),
      .limit   (limVec[g]),
      .reached (hitVec[g])
    );
  end

  assign pqDone   = hitVec[0];
  assign fastDone = hitVec[1] && (fastSel != 2'b00);
  assign topDone  = hitVec[2];

  // R8: a disabled fast timer never reports expiry
  p_fast_disabled_r8: assert property (@(posedge clk) disable iff (!rstN)
    (fastSel == 2'b00) |-> !fastDone);

endmodule

// File: rtl/chg_ctrl_fsm.sv
module chg_ctrl_fsm
  import chg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       chgEnable,
  input  logic       powerGood,
  input  logic       battAbovePq,
  input  logic       battAtReg,
  input  logic       currBelowTerm,
  input  logic       currBelowCcLow,
  input  logic       supplementMode,
  input  logic [2:0] tempZone,
  input  logic       pqDone,
  input  logic       fastDone,
  input  logic       topDone,
  output tmrCtl_t    tmrCtl,
  output logic [3:0] stateCode,
  output logic       charging,
  output logic       timerSuspended,
  output logic       stateChangePulse
);
  chgState_e state, nxt, resumeSt, resumeNxt;
  logic      modSeen, modSeenNow;
  logic      active, tempBad, tempMod;
  logic      inCc, inCv, inTop, inCharge, suspend;

  function automatic chgState_e withZone(chgState_e base, logic useMod);
    if (useMod && (base == ST_CC || base == ST_CV || base == ST_TOP))
      return chgState_e'(base + 4'd1);
    return base;
  endfunction

  always_comb begin
    active     = chgEnable && powerGood;
    tempBad    = (tempZone == ZONE_COLD) || (tempZone == ZONE_HOT);
    tempMod    = (tempZone == ZONE_COOL) || (tempZone == ZONE_WARM);
    inCc       = (state == ST_CC)  || (state == ST_CC_T);
    inCv       = (state == ST_CV)  || (state == ST_CV_T);
    inTop      = (state == ST_TOP) || (state == ST_TOP_T);
    inCharge   = (state >= ST_PREQ) && (state <= ST_TOP_T);
    modSeenNow = modSeen || (state == ST_CC_T) || (state == ST_CV_T) || (state == ST_TOP_T);
    suspend    = (inCc && currBelowCcLow) || (inCharge && supplementMode) ||
                 (state == ST_TEMP_FLT);
  end

  always_comb begin
    nxt = state;
    if (!active) begin
      nxt = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF:  nxt = tempBad ? ST_TEMP_FLT : ST_PREQ;
        ST_PREQ: begin
          if (tempBad)          nxt = ST_TEMP_FLT;
          else if (pqDone)      nxt = ST_PQ_FLT;
          else if (battAbovePq) nxt = withZone(ST_CC, tempMod);
        end
        ST_CC, ST_CC_T: begin
          if (tempBad)          nxt = ST_TEMP_FLT;
          else if (fastDone)    nxt = ST_FC_FLT;
          else if (battAtReg)   nxt = withZone(ST_CV, tempMod);
          else                  nxt = withZone(ST_CC, tempMod);
        end
        ST_CV, ST_CV_T: begin
          if (tempBad)            nxt = ST_TEMP_FLT;
          else if (fastDone)      nxt = ST_FC_FLT;
          else if (currBelowTerm) nxt = withZone(ST_TOP, tempMod);
          else                    nxt = withZone(ST_CV, tempMod);
        end
        ST_TOP, ST_TOP_T: begin
          if (tempBad)      nxt = ST_TEMP_FLT;
          else if (topDone) nxt = modSeenNow ? ST_DONE_T : ST_DONE;
          else              nxt = withZone(ST_TOP, tempMod);
        end
        ST_DONE, ST_DONE_T: if (tempBad) nxt = ST_TEMP_FLT;
        ST_PQ_FLT, ST_FC_FLT: nxt = state;
        ST_TEMP_FLT: if (!tempBad) nxt = withZone(resumeSt, tempMod);
        default: nxt = ST_OFF;
      endcase
    end
  end

  // phase to resume after a temperature fault, held as its normal variant
  always_comb begin
    resumeNxt = resumeSt;
    if (nxt == ST_TEMP_FLT && state != ST_TEMP_FLT) begin
      if (state == ST_OFF)
        resumeNxt = ST_PREQ;
      else if (state == ST_CC_T || state == ST_CV_T || state == ST_TOP_T)
        resumeNxt = chgState_e'(state - 4'd1);
      else
        resumeNxt = state;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state            <= ST_OFF;
      resumeSt         <= ST_PREQ;
      modSeen          <= 1'b0;
      stateChangePulse <= 1'b0;
    end else begin
      state            <= nxt;
      resumeSt         <= resumeNxt;
      modSeen          <= (state == ST_OFF) ? 1'b0 : modSeenNow;
      stateChangePulse <= (nxt != state);
    end
  end

  always_comb begin
    tmrCtl.holdClear = (state == ST_OFF);
    tmrCtl.runPq     = (state == ST_PREQ) && !suspend;
    tmrCtl.runFast   = (inCc || inCv) && !suspend;
    tmrCtl.runTop    = inTop && !suspend;
  end

  assign stateCode      = state;
  assign charging       = inCharge && !supplementMode;
  assign timerSuspended = suspend;

  p_code_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    stateCode < 4'd13);

  p_off_on_loss_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(chgEnable && powerGood) |=> (stateCode == 4'd0));

  p_temp_fault_r9: assert property (@(posedge clk) disable iff (!rstN)
    (chgEnable && powerGood && tempBad && stateCode >= 4'd1 && stateCode <= 4'd9)
      |=> (stateCode == 4'd12));

  p_pq_fault_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 4'd10 && chgEnable && powerGood) |=> (stateCode == 4'd10));

  p_pulse_change_r12: assert property (@(posedge clk) disable iff (!rstN)
    stateChangePulse == (stateCode != $past(stateCode)));

  p_charging_r11: assert property (@(posedge clk) disable iff (!rstN)
    charging |-> (!supplementMode && stateCode != 4'd0 && stateCode < 4'd8));

endmodule

// File: rtl/chg_mode_ctrl.sv
module chg_mode_ctrl
  import chg_pkg::*;
#(
  parameter int PQ_LIMIT_MIN    = 30,
  parameter int HOUR_MIN        = 60,
  parameter int TOPOFF_STEP_MIN = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       chgEnable,
  input  logic       powerGood,
  input  logic       battAbovePq,
  input  logic       battAtReg,
  input  logic       currBelowTerm,
  input  logic       currBelowCcLow,
  input  logic       supplementMode,
  input  logic [2:0] tempZone,
  input  logic [1:0] fastSel,
  input  logic [2:0] topSel,
  input  logic       minuteTick,
  output logic [3:0] stateCode,
  output logic       charging,
  output logic       timerSuspended,
  output logic       stateChangePulse
);
  tmrCtl_t tmrCtl;
  logic    pqDone, fastDone, topDone;

  chg_ctrl_fsm u_ctrl (
    .clk              (clk),
    .rstN             (rstN),
    .chgEnable        (chgEnable),
    .powerGood        (powerGood),
    .battAbovePq      (battAbovePq),
    .battAtReg        (battAtReg),
    .currBelowTerm    (currBelowTerm),
    .currBelowCcLow   (currBelowCcLow),
    .supplementMode   (supplementMode),
    .tempZone         (tempZone),
    .pqDone           (pqDone),
    .fastDone         (fastDone),
    .topDone          (topDone),
    .tmrCtl           (tmrCtl),
    .stateCode        (stateCode),
    .charging         (charging),
    .timerSuspended   (timerSuspended),
    .stateChangePulse (stateChangePulse)
  );

  chg_timer_dp #(
    .PQ_LIMIT_MIN    (PQ_LIMIT_MIN),
    .HOUR_MIN        (HOUR_MIN),
    .TOPOFF_STEP_MIN (TOPOFF_STEP_MIN)
  ) u_tmr (
    .clk        (clk),
    .rstN       (rstN),
    .minuteTick (minuteTick),
    .ctl        (tmrCtl),
    .fastSel    (fastSel),
    .topSel     (topSel),
    .pqDone     (pqDone),
    .fastDone   (fastDone),
    .topDone    (topDone)
  );

endmodule

// File: tb/tb_chg_mode_ctrl.sv
module tb_chg_mode_ctrl;
  localparam int PQ_LIM = 3;
  localparam int HOUR   = 2;
  localparam int STEP   = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chgEnable = 0, powerGood = 0, battAbovePq = 0, battAtReg = 0;
  logic currBelowTerm = 0, currBelowCcLow = 0, supplementMode = 0, minuteTick = 0;
  logic [2:0] tempZone = 3'd5;
  logic [1:0] fastSel = 2'd0;
  logic [2:0] topSel = 3'd0;
  logic [3:0] stateCode;
  logic charging, timerSuspended, stateChangePulse;

  int total = 0, bad = 0, pulseMismatch = 0;
  logic [3:0] prevCode = 4'd0;

  always #5 clk = ~clk;

  chg_mode_ctrl #(.PQ_LIMIT_MIN(PQ_LIM), .HOUR_MIN(HOUR), .TOPOFF_STEP_MIN(STEP)) dut (
    .clk(clk), .rstN(rstN), .chgEnable(chgEnable), .powerGood(powerGood),
    .battAbovePq(battAbovePq), .battAtReg(battAtReg), .currBelowTerm(currBelowTerm),
    .currBelowCcLow(currBelowCcLow), .supplementMode(supplementMode), .tempZone(tempZone),
    .fastSel(fastSel), .topSel(topSel), .minuteTick(minuteTick), .stateCode(stateCode),
    .charging(charging), .timerSuspended(timerSuspended), .stateChangePulse(stateChangePulse)
  );

  // R12 monitor: pulse must coincide with each code change
  always @(negedge clk) begin
    if (rstN) begin
      if (stateChangePulse != (stateCode != prevCode)) pulseMismatch++;
      prevCode = stateCode;
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      minuteTick = 1'b1; cyc(1); minuteTick = 1'b0;
    end
  endtask

  task automatic goOff();
    chgEnable = 0; battAbovePq = 0; battAtReg = 0; currBelowTerm = 0;
    currBelowCcLow = 0; supplementMode = 0; tempZone = 3'd5;
    cyc(1);
    chk(stateCode, 0, "R2 off after disable");
  endtask

  task automatic toCc(input logic [2:0] z);
    tempZone = z; chgEnable = 1; powerGood = 1; cyc(1);
    battAbovePq = 1; cyc(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3); rstN = 1'b1; cyc(1);
    chk(stateCode, 0, "R1 reset code");
    chk(charging, 0, "R1 reset charging");
    chk(timerSuspended, 0, "R1 reset suspended");
    chk(stateChangePulse, 0, "R1 reset pulse");
    powerGood = 1;

    // R3: zone sweep from off
    for (int z = 0; z < 6; z++) begin
      tempZone = 3'(z); chgEnable = 1; cyc(1);
      chk(stateCode, (z == 1 || z == 4) ? 12 : 1, "R3 entry by zone");
      chk(charging, (z == 1 || z == 4) ? 0 : 1, "R11 charging on entry");
      goOff();
    end

    // R4: full normal sequence for every top-off select
    for (int s = 0; s < 8; s++) begin
      topSel = 3'(s); fastSel = 0;
      toCc(3'd5);
      chk(stateCode, 2, "R4 precharge to cc");
      battAtReg = 1; cyc(1);
      chk(stateCode, 4, "R4 cc to cv");
      currBelowTerm = 1; cyc(1);
      chk(stateCode, 6, "R4 cv to topoff");
      if (s == 0) cyc(1);
      for (int k = 1; k <= s * STEP; k++) begin
        tick(1); cyc(1);
        chk(stateCode, (k < s * STEP) ? 6 : 8, "R4 topoff duration");
      end
      chk(stateCode, 8, "R6 normal done code");
      chk(stateChangePulse, 1, "R12 pulse at done");
      cyc(1);
      chk(stateChangePulse, 0, "R12 pulse one cycle");
      goOff();
    end

    // R5/R6: variants follow the zone; done is 9 after any adjusted phase
    topSel = 1;
    toCc(3'd2);
    chk(stateCode, 3, "R5 cool cc");
    tempZone = 3'd5; cyc(1);
    chk(stateCode, 2, "R5 back to normal cc");
    battAtReg = 1; cyc(1);
    chk(stateCode, 4, "R5 normal cv");
    tempZone = 3'd3; cyc(1);
    chk(stateCode, 5, "R5 warm cv");
    tempZone = 3'd5; currBelowTerm = 1; cyc(1);
    chk(stateCode, 6, "R5 normal topoff");
    tick(1); cyc(1);
    chk(stateCode, 9, "R6 adjusted done");
    goOff();

    // R7: precharge limit, colliding with the threshold crossing
    tempZone = 3'd5; chgEnable = 1; cyc(1);
    tick(PQ_LIM - 1); cyc(1);
    chk(stateCode, 1, "R7 before limit");
    tick(1);
    battAbovePq = 1; cyc(1);
    chk(stateCode, 10, "R7 fault wins over crossing");
    tempZone = 3'd1; cyc(3);
    chk(stateCode, 10, "R7 fault held");
    goOff();

    // R8: fast timer per select, final collision with termination in cv
    for (int s = 1; s < 4; s++) begin
      fastSel = 2'(s);
      toCc(3'd5);
      tick((2 * s + 1) * HOUR - 1); cyc(1);
      chk(stateCode, 2, "R8 before limit");
      battAtReg = 1; cyc(1);
      chk(stateCode, 4, "R8 cv under timer");
      tick(1);
      currBelowTerm = 1; cyc(1);
      chk(stateCode, 11, "R8 fault wins over termination");
      goOff();
    end
    fastSel = 0;
    toCc(3'd5);
    tick(20); cyc(1);
    chk(stateCode, 2, "R8 disabled timer");
    goOff();

    // R10: low-current suspension in cc
    fastSel = 1;
    toCc(3'd5);
    currBelowCcLow = 1; cyc(1);
    chk(timerSuspended, 1, "R10 low current suspends");
    tick(10); cyc(1);
    chk(stateCode, 2, "R10 no advance while suspended");
    currBelowCcLow = 0; cyc(1);
    chk(timerSuspended, 0, "R10 released");
    tick(3 * HOUR - 1); cyc(1);
    chk(stateCode, 2, "R10 count resumes");
    tick(1); cyc(1);
    chk(stateCode, 11, "R10 expiry after resumed count");
    goOff();

    // R10/R11: supplement mode in precharge
    chgEnable = 1; cyc(1);
    supplementMode = 1; cyc(1);
    chk(charging, 0, "R11 no charge in supplement");
    chk(timerSuspended, 1, "R10 supplement suspends");
    tick(5); cyc(1);
    chk(stateCode, 1, "R10 pq frozen");
    supplementMode = 0; cyc(1);
    chk(charging, 1, "R11 charging resumes");
    tick(PQ_LIM); cyc(1);
    chk(stateCode, 10, "R7 fault after resumed count");
    goOff();

    // R9: temperature fault in cv keeps fast timer progress
    fastSel = 1;
    toCc(3'd3);
    battAtReg = 1; cyc(1);
    chk(stateCode, 5, "R5 warm cv");
    tick(2);
    tempZone = 3'd4; cyc(1);
    chk(stateCode, 12, "R9 hot fault");
    chk(timerSuspended, 1, "R10 suspended in fault");
    tick(10);
    tempZone = 3'd2; cyc(1);
    chk(stateCode, 5, "R9 resume cv variant");
    tick(3 * HOUR - 3); cyc(1);
    chk(stateCode, 5, "R9 timer kept");
    tick(1); cyc(1);
    chk(stateCode, 11, "R9 expiry counts pre-fault ticks");
    goOff();

    // R2: timers restart after returning to off
    toCc(3'd5);
    tick(3 * HOUR - 1); cyc(1);
    chk(stateCode, 2, "R2 timer restarted");
    powerGood = 0; cyc(1);
    chk(stateCode, 0, "R2 off on power loss");
    powerGood = 1; goOff();

    chk(pulseMismatch, 0, "R12 pulse monitor");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule